// File: doc/BRIEF.md
# Active-Low Decimal Priority Encoder

The block takes nine request lines, one for each decimal digit from 1 to 9. Each line is active low. It returns a four-bit code for the highest-numbered request that is pulled low. The code is also active low: it is the bitwise inverse of the digit's BCD value. Digit zero has no line of its own. When every request line is high, the output is all ones, which reads as zero after inversion.

Typical uses are a keypad or an interrupt-style selector where the larger digit always wins. The priority search is purely combinational. An output stage, on by default, can register the code on a rising clock edge and clear it to the zero code with a synchronous reset. With the stage off, the code follows the inputs with no clock at all.

Top module: `dec_prio_enc`

## Requirements
- R1: Line `req_n[k-1]` requests digit k, for k from 1 to 9. A line asserts its request when it is driven low.
- R2: When `req_n[8]` is low, the code is 4'b0110, whatever the other eight lines hold.
- R3: The code equals the bitwise inverse of the 4-bit binary value of the highest asserted digit. For example, digit 8 gives 4'b0111 and digit 3 gives 4'b1100.
- R4: With all nine lines high, the code is 4'b1111, the zero code.
- R5: A digit below 9 is encoded only when every higher-numbered line is high. For example, digit 7 gives 4'b1000 only while `req_n[8:7]` is 2'b11, and digit 1 alone gives 4'b1110.
- R6: The code never takes a value from 4'b0000 to 4'b0101, since those would stand for digits 10 to 15.
- R7: With the registered stage on, the code shows the result for the inputs sampled at the previous rising clock edge. An edge that sees `rst` high sets the code to 4'b1111 instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high, clears the code to the zero code |
| req_n | input | 9 | Active-low request lines; bit k-1 stands for digit k |
| code_n | output | 4 | Active-low BCD code of the winning digit |

## Verification
Two functions can meet in one clock cycle.

The first pair is several requests present together. Here the priority search must pick the highest line and ignore the rest. A sweep over all 512 input patterns covers every such mix. Each result is compared with a reference scan computed in the bench, which works down from digit 9.

The second pair is the synchronous reset and a live request on the same edge. To provoke it, the bench holds digit 9 low while asserting reset. It judges the outcome by requiring the zero code on that edge. It then requires 4'b0110 on the first edge after reset is released.

// File: rtl/dpe_pkg.sv
package dpe_pkg;

    // Output stage variants selected by the top-level parameter
    typedef enum logic {
        STAGE_COMB = 1'b0,
        STAGE_REG  = 1'b1
    } stage_e;

    // Width of a code able to hold every digit from zero to n_lines
    function automatic int code_width(input int n_lines);
        return $clog2(n_lines + 1);
    endfunction

endpackage

// File: rtl/dpe_scan.sv
module dpe_scan #(
    parameter int NUM_LINES = 9,
    parameter int CODE_W    = 4
) (
    input  logic [NUM_LINES-1:0] act,
    output logic [CODE_W-1:0]    idx
);

    // Walk upward; a later hit overwrites, so the highest digit wins.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (act[i]) begin
                idx = CODE_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/dpe_drive.sv
module dpe_drive
    import dpe_pkg::*;
#(
    parameter int     CODE_W = 4,
    parameter stage_e STAGE  = STAGE_REG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] idx,
    output logic [CODE_W-1:0] code_n
);

    logic [CODE_W-1:0] code_d;

    assign code_d = ~idx;

    generate
        if (STAGE == STAGE_REG) begin : g_reg
            logic [CODE_W-1:0] code_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    code_q <= '1;
                end else begin
                    code_q <= code_d;
                end
            end
            assign code_n = code_q;
        end else begin : g_comb
            logic unused_ok;
            assign unused_ok = clk ^ rst;
            assign code_n    = code_d;
        end
    endgenerate

endmodule

// File: rtl/dec_prio_enc.sv
module dec_prio_enc
    import dpe_pkg::*;
#(
    parameter int     NUM_LINES = 9,
    parameter stage_e STAGE     = STAGE_REG,
    localparam int    CODE_W    = code_width(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] req_n,
    output logic [CODE_W-1:0]    code_n
);

    logic [NUM_LINES-1:0] req_act;
    logic [CODE_W-1:0]    win_idx;

    // Requests are active low; turn them active high for the search.
    assign req_act = ~req_n;

    dpe_scan #(
        .NUM_LINES (NUM_LINES),
        .CODE_W    (CODE_W)
    ) u_scan (
        .act (req_act),
        .idx (win_idx)
    );

    dpe_drive #(
        .CODE_W (CODE_W),
        .STAGE  (STAGE)
    ) u_drive (
        .clk    (clk),
        .rst    (rst),
        .idx    (win_idx),
        .code_n (code_n)
    );

endmodule

// File: rtl/dec_prio_enc_chk.sv
module dec_prio_enc_chk
    import dpe_pkg::*;
#(
    parameter int     NUM_LINES = 9,
    parameter stage_e STAGE     = STAGE_REG,
    parameter int     CODE_W    = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] req_n,
    input logic [CODE_W-1:0]    code_n
);

    localparam logic [CODE_W-1:0] TOP_CODE  = ~CODE_W'(NUM_LINES);
    localparam logic [CODE_W-1:0] ONE_CODE  = ~CODE_W'(1);
    localparam logic [NUM_LINES-1:0] ONLY_ONE = ~NUM_LINES'(1);

    generate
        if (STAGE == STAGE_REG) begin : g_reg
            p_top_wins_r2: assert property (@(posedge clk) disable iff (rst)
                !req_n[NUM_LINES-1] |=> code_n == TOP_CODE);
            p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
                (&req_n) |=> code_n == '1);
            p_lowest_alone_r5: assert property (@(posedge clk) disable iff (rst)
                (req_n == ONLY_ONE) |=> code_n == ONE_CODE);
        end else begin : g_comb
            p_top_wins_r2: assert property (@(posedge clk) disable iff (rst)
                !req_n[NUM_LINES-1] |-> code_n == TOP_CODE);
            p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
                (&req_n) |-> code_n == '1);
            p_lowest_alone_r5: assert property (@(posedge clk) disable iff (rst)
                (req_n == ONLY_ONE) |-> code_n == ONE_CODE);
        end
    endgenerate

    p_no_illegal_r6: assert property (@(posedge clk) disable iff (rst)
        (~code_n) <= CODE_W'(NUM_LINES));

endmodule

bind dec_prio_enc dec_prio_enc_chk #(
    .NUM_LINES (NUM_LINES),
    .STAGE     (STAGE),
    .CODE_W    (CODE_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .req_n  (req_n),
    .code_n (code_n)
);

// File: tb/dec_prio_enc_bench.sv
`timescale 1ns/1ps
module dec_prio_enc_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] req_n = '1;
    logic [3:0] code_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dec_prio_enc u_dec_prio_enc (
        .clk    (clk),
        .rst    (rst),
        .req_n  (req_n),
        .code_n (code_n)
    );

    // Reference: scan down from digit 9, first low line wins.
    function automatic logic [3:0] ref_code(input logic [8:0] r);
        for (int d = 9; d >= 1; d--) begin
            if (!r[d-1]) return ~4'(d);
        end
        return 4'b1111;
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        checks++;
        if (code_n !== exp) begin
            errors++;
            $display("FAIL %s req_n=%b actual=%b expected=%b", tag, req_n, code_n, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge register it, sample after.
    task automatic apply(input logic [8:0] r);
        @(negedge clk);
        req_n = r;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R7: reset holds the zero code even with digit 9 requested
        @(negedge clk);
        req_n = 9'b0_1111_1111;
        @(posedge clk);
        #1;
        check("R7 reset wins", 4'b1111);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R7 first edge after reset R2", 4'b0110);

        // R4: idle pattern
        apply(9'h1FF);
        check("R4 all high", 4'b1111);
        // R5: digit 1 alone, digit 7 with 8,9 high
        apply(9'b1_1111_1110);
        check("R5 digit 1 alone", 4'b1110);
        apply(9'b1_1011_1111);
        check("R5 digit 7", 4'b1000);
        apply(9'b1_0000_0000);
        check("R3 digit 8 over all lower", 4'b0111);
        apply(9'b0_0000_0000);
        check("R2 all low", 4'b0110);

        // R1 R3 R6: exhaustive sweep
        for (int p = 0; p < 512; p++) begin
            apply(9'(p));
            check("R3 sweep", ref_code(9'(p)));
            checks++;
            if (~code_n > 4'd9) begin
                errors++;
                $display("FAIL R6 req_n=%b actual=%b expected=code above 0101", req_n, code_n);
            end
            if (!req_n[8]) begin
                checks++;
                if (code_n !== 4'b0110) begin
                    errors++;
                    $display("FAIL R2 req_n=%b actual=%b expected=0110", req_n, code_n);
                end
            end
        end

        // R1: each single line on its own
        for (int d = 1; d <= 9; d++) begin
            apply(~(9'(1) << (d - 1)));
            check("R1 single line", ~4'(d));
        end

        // R7: reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        req_n = 9'b1_1110_1111;
        @(posedge clk);
        #1;
        check("R7 mid-run reset", 4'b1111);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R7 after release digit 5", 4'b1010);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule